// File: doc/BRIEF.md
# Bus Cycle Wait State Inserter

This block steps a CPU-side bus transfer through its phases: a first address phase, a command phase, a ready-sampling phase, any number of inserted wait phases, and a closing phase. The sequencer runs off the fast system clock but moves only when a CPU clock enable pulses, which in the target system happens on every third system clock. A wait phase is therefore always one whole CPU cycle.

A peripheral signals that it can finish the transfer through a raw ready line. That line passes through a one-CPU-cycle synchronizing register before the sequencer looks at it, so the sequencer always acts on the value the line had one CPU cycle earlier. During the ready-sampling phase, and during each wait phase after it, a low synchronized ready adds another wait phase. A high synchronized ready moves the cycle to its closing phase. A transfer tagged as I/O always gets at least one wait phase, even when the peripheral is ready at once. When the closing phase begins, the block raises a one-clock done strobe and presents the number of wait phases that the transfer carried.

Top module: `bus_wait_seq`

## Requirements
- R1: After a synchronous active-high reset, `phase` is 0 (idle), `done` is 0 and `wait_cnt` is 0.
- R2: `phase` changes only on a rising clock edge where `cpu_ce` is 1. While `cpu_ce` stays 0, a held `start` leaves `phase` at idle.
- R3: Phase codes are idle=0, T1=1, T2=2, T3=3, Tw=4 and T4=5. The only legal moves are idle→T1 (on `start`), T1→T2, T2→T3, T3→Tw or T3→T4, Tw→Tw or Tw→T4, T4→T1 (on `start`) and T4→idle.
- R4: In a memory cycle (`is_io`=0), T3 moves to T4 when the synchronized ready is 1. Otherwise a Tw is inserted, and Tw repeats until the synchronized ready is 1.
- R5: The ready decision made at CPU tick t uses `rdy_raw` as it was at tick t-1. If the tick that enters T1 is counted as tick 0 and `rdy_raw` is low for ticks 0..L-1 and high from tick L, a memory cycle carries max(0, L-2) wait phases.
- R6: An I/O cycle (`is_io`=1, captured at T1 entry) always moves from T3 to Tw and carries max(1, L-2) wait phases. With ready already high, that count is 1.
- R7: `done` is high for exactly one system clock, at the clock edge that enters T4. In that clock, `wait_cnt` equals the number of Tw phases in the cycle that is ending.
- R8: If `start` is high at the tick that ends T4, the next phase is T1 with no idle phase between. The wait count is cleared at every T1 entry.
- R9: `wait_cnt` saturates at 2^WAIT_W-1 (15 by default) and does not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_ce | input | 1 | CPU clock enable, one system clock wide |
| start | input | 1 | Request for a bus cycle |
| is_io | input | 1 | 1 = I/O cycle, 0 = memory cycle, captured at T1 entry |
| rdy_raw | input | 1 | Unsynchronized peripheral ready |
| phase | output | 3 | Current bus phase code (see R3) |
| done | output | 1 | One-clock strobe when T4 is entered |
| wait_cnt | output | WAIT_W | Wait phases inserted in the current cycle |

## Verification
The case that is hardest to reach from the ports is a ready edge that lands exactly where the synchronizer's one-tick delay matters. The release must fall on ticks 2, 3 or 4 of a cycle, where a release one tick earlier or later changes the wait count by one, or is hidden entirely by the forced I/O wait. The driver counts CPU ticks itself from the tick that enters T1 and releases `rdy_raw` at a chosen tick L. It runs L from 0 to 6 for both cycle types, with back-to-back and gapped starts. A long hold-off drives the count into saturation.

// File: rtl/bws_pkg.sv
package bws_pkg;
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_T1   = 3'd1,
    PH_T2   = 3'd2,
    PH_T3   = 3'd3,
    PH_TW   = 3'd4,
    PH_T4   = 3'd5
  } phase_t;
endpackage

// File: rtl/bws_rdy_sync.sv
module bws_rdy_sync (
  input  logic clk,
  input  logic rst,
  input  logic ce,
  input  logic rdy_in,
  output logic rdy_s
);
  always_ff @(posedge clk) begin
    if (rst)     rdy_s <= 1'b0;
    else if (ce) rdy_s <= rdy_in;
  end

  // R5: the synchronized copy moves only on a CPU tick
  a_r5_sync_on_tick: assert property (@(posedge clk) disable iff (rst)
    (!$past(ce) && !$past(rst)) |-> $stable(rdy_s));
endmodule

// File: rtl/bws_wait_ctr.sv
module bws_wait_ctr #(
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              inc,
  output logic [WAIT_W-1:0] cnt
);
  localparam logic [WAIT_W-1:0] CNT_MAX = {WAIT_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst || clr)                   cnt <= '0;
    else if (inc && (cnt != CNT_MAX)) cnt <= cnt + 1'b1;
  end

  a_r9_saturate: assert property (@(posedge clk) disable iff (rst)
    (cnt == CNT_MAX && !clr) |=> (cnt == CNT_MAX));
endmodule

// File: rtl/bws_phase_fsm.sv
module bws_phase_fsm
  import bws_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   ce,
  input  logic   start,
  input  logic   is_io,
  input  logic   rdy_s,
  output phase_t phase,
  output logic   io_q,
  output logic   done,
  output logic   clr_cnt,
  output logic   inc_cnt
);
  phase_t nxt;

  always_comb begin
    nxt = phase;
    case (phase)
      PH_IDLE: if (start) nxt = PH_T1;
      PH_T1:   nxt = PH_T2;
      PH_T2:   nxt = PH_T3;
      PH_T3:   nxt = (io_q || !rdy_s) ? PH_TW : PH_T4;
      PH_TW:   nxt = rdy_s ? PH_T4 : PH_TW;
      PH_T4:   nxt = start ? PH_T1 : PH_IDLE;
      default: nxt = PH_IDLE;
    endcase
  end

  assign clr_cnt = ce && (nxt == PH_T1) && (phase != PH_T1);
  assign inc_cnt = ce && (nxt == PH_TW);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IDLE;
      io_q  <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (ce) begin
        phase <= nxt;
        done  <= (nxt == PH_T4) && (phase != PH_T4);
        if (clr_cnt) io_q <= is_io;
      end
    end
  end

  a_r2_hold_without_ce: assert property (@(posedge clk) disable iff (rst)
    (!$past(ce) && !$past(rst)) |-> $stable(phase));
  a_r3_t3_exit: assert property (@(posedge clk) disable iff (rst)
    ($past(phase) == PH_T3 && phase != PH_T3) |-> (phase == PH_TW || phase == PH_T4));
  a_r7_done_in_t4: assert property (@(posedge clk) disable iff (rst)
    done |-> (phase == PH_T4));
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: rtl/bus_wait_seq.sv
module bus_wait_seq #(
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_ce,
  input  logic              start,
  input  logic              is_io,
  input  logic              rdy_raw,
  output logic [2:0]        phase,
  output logic              done,
  output logic [WAIT_W-1:0] wait_cnt
);
  import bws_pkg::*;

  logic   rdy_s, io_q, clr_cnt, inc_cnt;
  phase_t ph;

  bws_rdy_sync u_sync (
    .clk(clk), .rst(rst), .ce(cpu_ce), .rdy_in(rdy_raw), .rdy_s(rdy_s)
  );

  bws_phase_fsm u_fsm (
    .clk(clk), .rst(rst), .ce(cpu_ce), .start(start), .is_io(is_io),
    .rdy_s(rdy_s), .phase(ph), .io_q(io_q), .done(done),
    .clr_cnt(clr_cnt), .inc_cnt(inc_cnt)
  );

  bws_wait_ctr #(.WAIT_W(WAIT_W)) u_ctr (
    .clk(clk), .rst(rst), .clr(clr_cnt), .inc(inc_cnt), .cnt(wait_cnt)
  );

  assign phase = ph;

  // R6: an I/O cycle never closes without a wait phase
  a_r6_io_min_wait: assert property (@(posedge clk) disable iff (rst)
    (done && io_q) |-> (wait_cnt != '0));
  // R1: reset state
  a_r1_reset_state: assert property (@(posedge clk)
    $past(rst) |-> (phase == 3'd0 && !done && wait_cnt == '0));
endmodule

// File: tb/bus_wait_seq_test.sv
module bus_wait_seq_test;
  localparam int WAIT_W = 4;
  localparam int WMAX   = (1 << WAIT_W) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ce_en = 1'b0;
  logic start = 1'b0, is_io = 1'b0, rdy_raw = 1'b0;
  logic [1:0] div = 2'd0;
  logic cpu_ce;
  logic [2:0] phase;
  logic done;
  logic [WAIT_W-1:0] wait_cnt;

  int checks = 0, fails = 0;
  int exp_q[$];
  logic [2:0] prev_ph = 3'd0;
  bit reported = 0;

  always #5 clk = ~clk;

  always_ff @(posedge clk) div <= (div == 2'd2) ? 2'd0 : div + 2'd1;
  assign cpu_ce = ce_en && (div == 2'd2);

  bus_wait_seq #(.WAIT_W(WAIT_W)) uut (
    .clk(clk), .rst(rst), .cpu_ce(cpu_ce), .start(start), .is_io(is_io),
    .rdy_raw(rdy_raw), .phase(phase), .done(done), .wait_cnt(wait_cnt)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
    end
  endtask

  // wait for one CPU tick; return at the next negedge
  task automatic tick();
    do @(negedge clk); while (!cpu_ce);
    @(posedge clk);
    @(negedge clk);
  endtask

  // R4 R5 R6: expected wait count model
  function automatic int model(input bit io, input int l);
    int w;
    w = l - 2;
    if (w < 0) w = 0;
    if (io && w < 1) w = 1;
    if (w > WMAX) w = WMAX;
    return w;
  endfunction

  // driver: entered at a negedge, leaves at the negedge after done
  task automatic run_cycle(input bit io, input int l);
    int t = 0;
    start = 1'b1;
    is_io = io;
    rdy_raw = (l == 0);
    exp_q.push_back(model(io, l));
    forever begin
      tick();
      if (done) break;
      t++;
      start = 1'b0;
      rdy_raw = (t >= l);
    end
  endtask

  // monitor: scoreboard compare on done, phase move legality (R3), pulse width (R7)
  always @(negedge clk) begin
    if (!rst) begin
      if (phase != prev_ph) begin
        bit legal;
        case (prev_ph)
          3'd0: legal = (phase == 3'd1);
          3'd1: legal = (phase == 3'd2);
          3'd2: legal = (phase == 3'd3);
          3'd3: legal = (phase == 3'd4 || phase == 3'd5);
          3'd4: legal = (phase == 3'd5);
          3'd5: legal = (phase == 3'd1 || phase == 3'd0);
          default: legal = 1'b0;
        endcase
        check(legal, "R3 phase move", phase, prev_ph);
      end
      if (done) begin
        if (exp_q.size() == 0) check(1'b0, "R7 unexpected done", 1, 0);
        else begin
          int e;
          e = exp_q.pop_front();
          check(wait_cnt == e, "R4/R5/R6/R9 wait count", wait_cnt, e);
          check(phase == 3'd5, "R7 done in T4", phase, 5);
        end
      end
      if (done && prev_done) check(1'b0, "R7 done wider than one clock", 2, 1);
    end
    prev_ph = phase;
    prev_done = done;
  end
  logic prev_done = 1'b0;

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    report();
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    check(phase == 3'd0, "R1 phase after reset", phase, 0);
    check(done == 1'b0, "R1 done after reset", done, 0);
    check(wait_cnt == 0, "R1 wait_cnt after reset", wait_cnt, 0);
    // R2: no ticks, start held
    start = 1'b1;
    repeat (10) @(negedge clk);
    check(phase == 3'd0, "R2 no move without cpu_ce", phase, 0);
    start = 1'b0;
    ce_en = 1'b1;
    repeat (6) @(negedge clk);
    // R4 R5 memory, back-to-back (R8)
    for (int l = 0; l <= 6; l++) run_cycle(1'b0, l);
    // R8: the last cycle ends in T4 with start; after next tick phase is T1
    start = 1'b1; is_io = 1'b0; rdy_raw = 1'b1;
    exp_q.push_back(0);
    tick();
    check(phase == 3'd1, "R8 T4 to T1 back-to-back", phase, 1);
    check(wait_cnt == 0, "R8 count cleared at T1", wait_cnt, 0);
    start = 1'b0;
    do tick(); while (!done);
    // R6 I/O cycles with gaps
    for (int l = 0; l <= 6; l++) begin
      start = 1'b0;
      repeat (2) tick();
      check(phase == 3'd0, "R3 idle between gapped cycles", phase, 0);
      run_cycle(1'b1, l);
    end
    // R9 saturation, memory and I/O
    run_cycle(1'b0, 30);
    run_cycle(1'b1, 25);
    // R5 boundary: release exactly at tick 3 and 4
    run_cycle(1'b0, 3);
    run_cycle(1'b1, 4);
    start = 1'b0;
    repeat (4) tick();
    check(exp_q.size() == 0, "R7 all cycles completed", exp_q.size(), 0);
    report();
    $finish;
  end
endmodule